// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Frame Sequencer

This block sits at the receive side of a serial NOR flash interface. It follows each chip-select frame and works out whether the frame opens with an 8-bit command byte or goes straight to a 24-bit address. In execute-in-place (XIP) operation the command is left out, so a host can fetch code by sending only an address. The block tracks the XIP state from frame to frame. It reports the captured command or address, the number of data lanes in use, and a one-cycle strobe when an address is complete.

XIP can be switched on in two ways. At power-on, a three-bit non-volatile field can start the device directly in single, dual or quad XIP. At run time, a volatile arm bit lets the next fast read enter XIP. In both cases the host controls what happens next through a confirmation bit. This bit is taken from DQ0 on the first dummy clock after the address. A 0 keeps or enters XIP. A 1 returns the device to command-first frames. All inputs are synchronous to `clk`, and an SCK rising edge is detected by sampling SCK against its previous value.

Top module: `spi_xip_sequencer`

## Requirements
- R1: While `porRst` is high, `xipActive` and `laneWidth` load from `nvXipType`: 3'b100 gives single (lane width 1), 3'b101 gives dual (2) and 3'b110 gives quad (4), each with `xipActive`=1. Every other code gives `xipActive`=0 and `laneWidth`=1.
- R2: A change on `nvXipType` while `porRst` is low has no effect on `xipActive` or `laneWidth`.
- R3: A frame that starts while `xipActive`=0 reports `frameAddrFirst`=0. It shifts a command byte in on DQ0, MSB first, one bit per SCK rising edge, and `opcode` shows that byte once the eighth bit has been taken.
- R4: Command 0x0B selects 1 lane, 0xBB selects 2 lanes and 0xEB selects 4 lanes. The address that follows is shifted MSB first: lanes DQ1..DQ0 in dual mode and DQ3..DQ0 in quad mode, with the higher lane carrying the more significant bit. `addrValid` pulses high for exactly one cycle with `address` holding the 24-bit value.
- R5: Any other command captures no address, and `addrValid` stays low for the rest of the frame.
- R6: In a command-first fast read with `volXipOff`=0 when the confirmation bit is sampled, a confirmation of 0 sets `xipActive`=1 with the lane width of that read. The next frame then reports `frameAddrFirst`=1 and starts with the address.
- R7: With `volXipOff`=1, a command-first fast read leaves `xipActive` at 0 whatever the confirmation bit is.
- R8: In an address-first frame, a confirmation of 0 keeps XIP. A confirmation of 1 clears `xipActive`, and the next frame starts with a command byte.
- R9: Only the first dummy SCK rising edge is sampled. DQ0 values on the remaining `DUMMY_CYCLES-1` dummy edges have no effect.
- R10: If `csN` rises before the confirmation bit is sampled, the frame is dropped and `xipActive` keeps its value. `xipActive` never changes while `csN` is high.
- R11: `laneWidth` is always 1, 2 or 4. Between frames and during an address-first frame it equals the XIP lane width in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are synchronous to it |
| porRst | input | 1 | Synchronous power-on reset, active high |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level, sampled by `clk` |
| dq | input | 4 | Serial data lanes DQ3..DQ0 |
| volXipOff | input | 1 | Volatile arm bit; 0 lets the next confirmed fast read enter XIP |
| nvXipType | input | 3 | Non-volatile XIP selection, read only during power-on reset |
| frameAddrFirst | output | 1 | 1 when the current or last frame began with an address |
| opcode | output | 8 | Last captured command byte |
| address | output | 24 | Last captured address |
| laneWidth | output | 3 | Lanes in use: 1, 2 or 4 |
| addrValid | output | 1 | One-cycle strobe when `address` is complete |
| xipActive | output | 1 | Current XIP status |

## Verification
The tests send command-first fast reads on each lane width with different address patterns, so that a wrong lane order or bit order gives a distinct wrong address. A non-read command and reads with the arm bit set or cleared show whether entry into XIP depends on both the arm bit and the confirmation bit. Address-first frames with confirmation 0, confirmation 1 and an early chip-select release separate the three outcomes: staying in XIP, leaving it, and dropping the frame. On every dummy edge after the first, DQ0 is driven with the value opposite to the confirmation bit, so sampling the wrong edge shows up as a wrong XIP state.

// File: rtl/spi_xip_pkg.sv
package spi_xip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA
  } seqStateT;

  typedef struct packed {
    logic       clearShift;
    logic       shiftEn;
    logic [2:0] lanes;
    logic       loadOp;
    logic       loadAddr;
  } ctrlStrobeT;

  // Lane count for a fast read command; 0 means not a fast read.
  function automatic logic [2:0] fastReadLanes(input logic [7:0] cmd);
    case (cmd)
      8'h0B:   return 3'd1;
      8'hBB:   return 3'd2;
      8'hEB:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Lane count selected by the non-volatile field; 0 means XIP off.
  function automatic logic [2:0] nvLanes(input logic [2:0] code);
    case (code)
      3'b100:  return 3'd1;
      3'b101:  return 3'd2;
      3'b110:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/spixip_datapath.sv
module spixip_datapath
  import spi_xip_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int OP_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 porRst,
  input  logic                 sck,
  input  logic [3:0]           dq,
  input  ctrlStrobeT           strb,
  output logic                 sckRise,
  output logic [OP_BITS-1:0]   nextOp,
  output logic [OP_BITS-1:0]   opcode,
  output logic [ADDR_BITS-1:0] address,
  output logic                 addrValid
);

  logic                 sckQ;
  logic [ADDR_BITS-1:0] shiftReg;
  logic [ADDR_BITS-1:0] shiftNext;

  assign sckRise = sck & ~sckQ;
  assign nextOp  = shiftNext[OP_BITS-1:0];

  always_comb begin
    case (strb.lanes)
      3'd4:    shiftNext = {shiftReg[ADDR_BITS-5:0], dq[3:0]};
      3'd2:    shiftNext = {shiftReg[ADDR_BITS-3:0], dq[1:0]};
      default: shiftNext = {shiftReg[ADDR_BITS-2:0], dq[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (porRst) begin
      sckQ      <= 1'b0;
      shiftReg  <= '0;
      opcode    <= '0;
      address   <= '0;
      addrValid <= 1'b0;
    end else begin
      sckQ      <= sck;
      addrValid <= strb.loadAddr;
      if (strb.clearShift)   shiftReg <= '0;
      else if (strb.shiftEn) shiftReg <= shiftNext;
      if (strb.loadOp)   opcode  <= nextOp;
      if (strb.loadAddr) address <= shiftNext;
    end
  end

endmodule

// File: rtl/spixip_control.sv
module spixip_control
  import spi_xip_pkg::*;
#(
  parameter int ADDR_BITS    = 24,
  parameter int OP_BITS      = 8,
  parameter int DUMMY_CYCLES = 8
) (
  input  logic               clk,
  input  logic               porRst,
  input  logic               csN,
  input  logic               sckRise,
  input  logic               dq0,
  input  logic               volXipOff,
  input  logic [2:0]         nvXipType,
  input  logic [OP_BITS-1:0] nextOp,
  output ctrlStrobeT         strb,
  output logic               frameAddrFirst,
  output logic [2:0]         laneWidth,
  output logic               xipActive
);

  localparam int MAX_EDGES = (ADDR_BITS > DUMMY_CYCLES) ? ADDR_BITS : DUMMY_CYCLES;
  localparam int CW        = $clog2(MAX_EDGES + 1);

  seqStateT      state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          lastEdge;
  logic [2:0]    xipLanes;
  logic [2:0]    frameLanes;
  logic [2:0]    opLanes;
  logic [2:0]    porLanes;

  assign opLanes   = fastReadLanes(nextOp);
  assign porLanes  = nvLanes(nvXipType);
  assign laneWidth = frameLanes;

  always_comb begin
    case (state)
      ST_OPCODE: limit = CW'(OP_BITS);
      ST_ADDR: begin
        case (frameLanes)
          3'd4:    limit = CW'(ADDR_BITS / 4);
          3'd2:    limit = CW'(ADDR_BITS / 2);
          default: limit = CW'(ADDR_BITS);
        endcase
      end
      ST_DUMMY: limit = CW'(DUMMY_CYCLES);
      default:  limit = CW'(1);
    endcase
    lastEdge        = (cnt == limit - 1'b1);
    strb.clearShift = (state == ST_IDLE);
    strb.shiftEn    = sckRise && (state == ST_OPCODE || state == ST_ADDR);
    strb.lanes      = frameLanes;
    strb.loadOp     = strb.shiftEn && (state == ST_OPCODE) && lastEdge;
    strb.loadAddr   = strb.shiftEn && (state == ST_ADDR) && lastEdge;
  end

  always_ff @(posedge clk) begin
    if (porRst) begin
      state          <= ST_IDLE;
      cnt            <= '0;
      xipActive      <= (porLanes != 3'd0);
      xipLanes       <= (porLanes != 3'd0) ? porLanes : 3'd1;
      frameLanes     <= (porLanes != 3'd0) ? porLanes : 3'd1;
      frameAddrFirst <= 1'b0;
    end else if (csN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      frameLanes <= xipActive ? xipLanes : 3'd1;
    end else begin
      case (state)
        ST_IDLE: begin
          frameAddrFirst <= xipActive;
          state          <= xipActive ? ST_ADDR : ST_OPCODE;
          cnt            <= '0;
        end
        ST_OPCODE: if (sckRise) begin
          if (lastEdge) begin
            cnt <= '0;
            if (opLanes != 3'd0) begin
              frameLanes <= opLanes;
              state      <= ST_ADDR;
            end else begin
              state <= ST_DATA;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (sckRise) begin
          if (lastEdge) begin
            cnt   <= '0;
            state <= ST_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: if (sckRise) begin
          if (cnt == '0) begin
            if (frameAddrFirst) begin
              xipActive <= ~dq0;
            end else if (!volXipOff && !dq0) begin
              xipActive <= 1'b1;
              xipLanes  <= frameLanes;
            end
          end
          if (lastEdge) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_DATA;
      endcase
    end
  end

endmodule

// File: rtl/spi_xip_sequencer.sv
module spi_xip_sequencer
  import spi_xip_pkg::*;
#(
  parameter int DUMMY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        porRst,
  input  logic        csN,
  input  logic        sck,
  input  logic [3:0]  dq,
  input  logic        volXipOff,
  input  logic [2:0]  nvXipType,
  output logic        frameAddrFirst,
  output logic [7:0]  opcode,
  output logic [23:0] address,
  output logic [2:0]  laneWidth,
  output logic        addrValid,
  output logic        xipActive
);

  localparam int ADDR_BITS = 24;
  localparam int OP_BITS   = 8;

  ctrlStrobeT         strb;
  logic               sckRise;
  logic [OP_BITS-1:0] nextOp;

  spixip_datapath #(
    .ADDR_BITS(ADDR_BITS),
    .OP_BITS  (OP_BITS)
  ) i_datapath (
    .clk      (clk),
    .porRst   (porRst),
    .sck      (sck),
    .dq       (dq),
    .strb     (strb),
    .sckRise  (sckRise),
    .nextOp   (nextOp),
    .opcode   (opcode),
    .address  (address),
    .addrValid(addrValid)
  );

  spixip_control #(
    .ADDR_BITS   (ADDR_BITS),
    .OP_BITS     (OP_BITS),
    .DUMMY_CYCLES(DUMMY_CYCLES)
  ) i_control (
    .clk           (clk),
    .porRst        (porRst),
    .csN           (csN),
    .sckRise       (sckRise),
    .dq0           (dq[0]),
    .volXipOff     (volXipOff),
    .nvXipType     (nvXipType),
    .nextOp        (nextOp),
    .strb          (strb),
    .frameAddrFirst(frameAddrFirst),
    .laneWidth     (laneWidth),
    .xipActive     (xipActive)
  );

endmodule

// File: rtl/spi_xip_sequencer_chk.sv
module spi_xip_sequencer_chk (
  input logic       clk,
  input logic       porRst,
  input logic       csN,
  input logic       frameAddrFirst,
  input logic [2:0] laneWidth,
  input logic       addrValid,
  input logic       xipActive
);

  // R4: the address strobe lasts one cycle
  p_addr_pulse_r4: assert property (@(posedge clk) disable iff (porRst)
    addrValid |=> !addrValid);

  // R11: lane width is one of 1, 2, 4
  p_lane_legal_r11: assert property (@(posedge clk) disable iff (porRst)
    $countones(laneWidth) == 1);

  // R10: XIP status is frozen while the chip is deselected
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (porRst)
    csN |=> $stable(xipActive));

  // R6: XIP is only entered from a command-first frame
  p_enter_std_r6: assert property (@(posedge clk) disable iff (porRst)
    $rose(xipActive) |-> !frameAddrFirst);

  // R8: XIP is only left from an address-first frame
  p_leave_xip_r8: assert property (@(posedge clk) disable iff (porRst)
    $fell(xipActive) |-> frameAddrFirst);

endmodule

bind spi_xip_sequencer spi_xip_sequencer_chk i_chk (
  .clk           (clk),
  .porRst        (porRst),
  .csN           (csN),
  .frameAddrFirst(frameAddrFirst),
  .laneWidth     (laneWidth),
  .addrValid     (addrValid),
  .xipActive     (xipActive)
);

// File: tb/test_spi_xip_sequencer.sv
module test_spi_xip_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int DUMMY      = 8;

  logic        clk = 1'b0;
  logic        porRst = 1'b1;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  dq = 4'h0;
  logic        volXipOff = 1'b1;
  logic [2:0]  nvXipType = 3'b111;
  logic        frameAddrFirst;
  logic [7:0]  opcode;
  logic [23:0] address;
  logic [2:0]  laneWidth;
  logic        addrValid;
  logic        xipActive;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [23:0] seenAddr = '0;
  bit done = 0;

  spi_xip_sequencer #(.DUMMY_CYCLES(DUMMY)) i_spi_xip_sequencer (
    .clk(clk), .porRst(porRst), .csN(csN), .sck(sck), .dq(dq),
    .volXipOff(volXipOff), .nvXipType(nvXipType),
    .frameAddrFirst(frameAddrFirst), .opcode(opcode), .address(address),
    .laneWidth(laneWidth), .addrValid(addrValid), .xipActive(xipActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (addrValid) begin
    pulses++;
    seenAddr = address;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sckEdge(input logic [3:0] d);
    @(negedge clk) dq = d; sck = 1'b0;
    @(negedge clk) sck = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic startFrame();
    @(negedge clk) csN = 1'b0; sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic endFrame();
    @(negedge clk) sck = 1'b0; csN = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendOp(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sckEdge({3'b000, b[i]});
  endtask

  task automatic sendAddr(input logic [23:0] a, input int lanes);
    for (int k = 24 / lanes - 1; k >= 0; k--)
      sckEdge(4'((a >> (k * lanes)) & 24'((1 << lanes) - 1)));
  endtask

  // first dummy carries conf, the rest carry its complement
  task automatic sendDummy(input logic conf);
    sckEdge({3'b000, conf});
    for (int i = 1; i < DUMMY; i++) sckEdge({3'b000, ~conf});
  endtask

  task automatic doReset(input logic [2:0] nv);
    @(negedge clk) porRst = 1'b1; nvXipType = nv;
    repeat (3) @(negedge clk);
    porRst = 1'b0;
    @(negedge clk);
  endtask

  task automatic tResetOff();
    doReset(3'b111);
    check(xipActive == 1'b0, "R1 xip off after reset", xipActive, 0);
    check(laneWidth == 3'd1, "R1 lane width after reset", laneWidth, 1);
  endtask

  task automatic tStdSingle();
    int p0 = pulses;
    volXipOff = 1'b1;
    startFrame();
    check(frameAddrFirst == 1'b0, "R3 command-first frame", frameAddrFirst, 0);
    sendOp(8'h0B);
    check(opcode == 8'h0B, "R3 opcode capture", opcode, 8'h0B);
    check(laneWidth == 3'd1, "R4 single lane", laneWidth, 1);
    sendAddr(24'hA5C3F1, 1);
    check(pulses - p0 == 1, "R4 one strobe", pulses - p0, 1);
    check(seenAddr == 24'hA5C3F1, "R4 single address", seenAddr, 24'hA5C3F1);
    sendDummy(1'b0);
    endFrame();
    check(xipActive == 1'b0, "R7 unarmed stays standard", xipActive, 0);
  endtask

  task automatic tStdDual();
    int p0 = pulses;
    volXipOff = 1'b1;
    startFrame();
    sendOp(8'hBB);
    check(laneWidth == 3'd2, "R4 dual lanes", laneWidth, 2);
    sendAddr(24'h2D81E7, 2);
    check(pulses - p0 == 1 && seenAddr == 24'h2D81E7, "R4 dual address", seenAddr, 24'h2D81E7);
    sendDummy(1'b0);
    endFrame();
    check(xipActive == 1'b0, "R7 dual unarmed", xipActive, 0);
  endtask

  task automatic tOtherCmd();
    int p0 = pulses;
    volXipOff = 1'b0;
    startFrame();
    sendOp(8'h9F);
    check(opcode == 8'h9F, "R3 other opcode", opcode, 8'h9F);
    for (int i = 0; i < 30; i++) sckEdge(4'h0);
    check(pulses == p0, "R5 no address capture", pulses - p0, 0);
    endFrame();
    check(xipActive == 1'b0, "R5 xip unchanged", xipActive, 0);
  endtask

  task automatic tArmIgnoredConf();
    volXipOff = 1'b0;
    startFrame();
    sendOp(8'h0B);
    sendAddr(24'h000001, 1);
    sendDummy(1'b1);
    endFrame();
    check(xipActive == 1'b0, "R9 later dummy zeros ignored", xipActive, 0);
  endtask

  task automatic tEnterQuad();
    int p0 = pulses;
    volXipOff = 1'b0;
    startFrame();
    sendOp(8'hEB);
    check(laneWidth == 3'd4, "R4 quad lanes", laneWidth, 4);
    sendAddr(24'h123456, 4);
    check(pulses - p0 == 1 && seenAddr == 24'h123456, "R4 quad address", seenAddr, 24'h123456);
    sendDummy(1'b0);
    check(xipActive == 1'b1, "R6 enter xip", xipActive, 1);
    endFrame();
    volXipOff = 1'b1;
    check(laneWidth == 3'd4, "R11 quad xip width", laneWidth, 4);
  endtask

  task automatic tXipKeep();
    int p0 = pulses;
    startFrame();
    check(frameAddrFirst == 1'b1, "R6 address-first frame", frameAddrFirst, 1);
    sendAddr(24'hFEDCBA, 4);
    check(pulses - p0 == 1 && seenAddr == 24'hFEDCBA, "R8 xip address", seenAddr, 24'hFEDCBA);
    sendDummy(1'b0);
    endFrame();
    check(xipActive == 1'b1, "R8 confirm 0 keeps xip", xipActive, 1);
  endtask

  task automatic tXipAbort();
    int p0 = pulses;
    startFrame();
    for (int i = 0; i < 3; i++) sckEdge(4'hF);
    endFrame();
    check(xipActive == 1'b1, "R10 abort keeps xip", xipActive, 1);
    check(pulses == p0, "R10 no strobe on abort", pulses - p0, 0);
  endtask

  task automatic tXipLeave();
    startFrame();
    sendAddr(24'h0A0B0C, 4);
    sendDummy(1'b1);
    endFrame();
    check(xipActive == 1'b0, "R8 confirm 1 leaves xip", xipActive, 0);
    check(laneWidth == 3'd1, "R11 width back to 1", laneWidth, 1);
    startFrame();
    check(frameAddrFirst == 1'b0, "R8 next frame command-first", frameAddrFirst, 0);
    sendOp(8'h0B);
    check(opcode == 8'h0B, "R8 command decoded", opcode, 8'h0B);
    endFrame();
  endtask

  task automatic tNvPower();
    int p0;
    @(negedge clk) nvXipType = 3'b101;
    repeat (4) @(negedge clk);
    check(xipActive == 1'b0, "R2 nv change ignored", xipActive, 0);
    check(laneWidth == 3'd1, "R2 width unchanged", laneWidth, 1);
    doReset(3'b101);
    check(xipActive == 1'b1, "R1 dual xip at power-on", xipActive, 1);
    check(laneWidth == 3'd2, "R1 dual width", laneWidth, 2);
    p0 = pulses;
    startFrame();
    check(frameAddrFirst == 1'b1, "R1 boots address-first", frameAddrFirst, 1);
    sendAddr(24'h0F0F33, 2);
    check(pulses - p0 == 1 && seenAddr == 24'h0F0F33, "R4 dual xip address", seenAddr, 24'h0F0F33);
    sendDummy(1'b0);
    endFrame();
    check(xipActive == 1'b1, "R8 dual xip kept", xipActive, 1);
    doReset(3'b011);
    check(xipActive == 1'b0, "R1 unused code disables", xipActive, 0);
  endtask

  initial begin
    tResetOff();
    tStdSingle();
    tStdDual();
    tOtherCmd();
    tArmIgnoredConf();
    tEnterQuad();
    tXipKeep();
    tXipAbort();
    tXipLeave();
    tNvPower();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule